// File: doc/BRIEF.md
# Output-Enable Request Input Filter

This block guards three active-low emergency request pins whose job is to force timer outputs into a safe off state. Each pin is brought into the clock domain through a two-flop synchronizer. It is then qualified either by a falling-edge detector or by a level filter. The level filter demands sixteen consecutive low samples. The sample strobe is taken from a shared free-running prescaler at one of three rates. A qualified request sets a sticky per-pin flag, and the OR of the flags is the combined request that would drive output disabling.

Software selects each pin's qualification mode through an 8-bit mode register and reads the flags back through a simple strobe-based register port. It clears individual flags by writing ones. When a pin's mode field changes, that pin's filter history restarts, so the switch itself never produces a request.

Top module: `oe_req_filter`

## Requirements
- R1: After reset the mode register reads 0x00, all request flags are 0 and the combined request is 0.
- R2: Address 0 is the mode register: bits 3:2 select the mode of pin 0, bits 5:4 pin 1 and bits 7:6 pin 2. Bits 1:0 are not stored and read as 0.
- R3: Mode code 00 (edge) sets a pin's flag on the third rising clock edge after the pin falls from high to low. A pin that is already low when edge mode is entered gives no request.
- R4: Mode codes 01, 10 and 11 sample the synchronized pin once every D = 8, 16 and 128 clocks. The flag sets after 16 consecutive low samples, which is between 15·D+3 and 16·D+2 rising edges after the pin falls.
- R5: In a level mode a low stretch of 15·D clocks gives no request. A single high sample, from a high interval of D clocks, restarts the count of low samples from zero.
- R6: Address 1 reads the flags in bits 2:0, bit n holding pin n. Writing 1 to bit n clears flag n, writing 0 leaves it unchanged, and a flag otherwise stays set.
- R7: A clear of a flag in the same cycle as a new acceptance on that pin leaves the flag set.
- R8: The three pins are qualified independently, each at its own configured rate, when their requests arrive together.
- R9: A write that changes a pin's mode field restarts that pin's filter. Level counting begins again from the write, and a pin that is low during the switch produces no request.
- R10: The combined request output is high exactly when at least one flag is set.
- R11: After a level-mode acceptance, a pin that stays low produces no further acceptance until it has been sampled high.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_req_n | input | 3 | Active-low emergency request pins, bit n is pin n |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 1 | Register select: 0 mode, 1 flags/clear |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for the selected address |
| req_flags | output | 3 | Sticky per-pin request flags |
| req_any | output | 1 | OR of all request flags |

## Verification
Single falling edges in edge mode are timed to the exact clock edge, which separates a correct two-stage synchronizer from a shorter or longer one. All three pins fall together with the three level rates rotated across them, and the measured acceptance times fall into windows around 16·D. These windows do not overlap, so a wrong tap or a pin wired to the wrong field shows up. Low stretches one sample too short, and two such stretches split by one high sample, test the all-low rule and the counter reset. A mode change in the middle of a count, a clear that lands on the acceptance edge, and a pin held low after a clear cover restart, flag priority and re-arming.

// File: rtl/oe_pkg.sv
package oe_pkg;

  typedef enum logic [1:0] {
    MODE_EDGE  = 2'b00,
    MODE_TAP_A = 2'b01,
    MODE_TAP_B = 2'b10,
    MODE_TAP_C = 2'b11
  } oe_mode_e;

  localparam int REG_W     = 8;
  localparam int FIELD_LSB = 2;

  // True in the last cycle of each period of length div.
  function automatic logic tap_hit(input int unsigned cnt, input int unsigned div);
    return (cnt % div) == (div - 1);
  endfunction

  // Bits of the mode register that hold a pin field.
  function automatic logic [REG_W-1:0] field_mask(input int unsigned pins);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < pins; i++) begin
      m[FIELD_LSB + 2*i +: 2] = 2'b11;
    end
    return m;
  endfunction

  // Sticky flag update: a new acceptance wins over a clear.
  function automatic logic next_flag(input logic flag, input logic accept, input logic clr);
    return accept | (flag & ~clr);
  endfunction

endpackage

// File: rtl/oe_prescaler.sv
module oe_prescaler #(
  parameter int DIV_A = 8,
  parameter int DIV_B = 16,
  parameter int DIV_C = 128
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_a,
  output logic tick_b,
  output logic tick_c
);
  import oe_pkg::*;

  localparam int CNT_W = (DIV_C > 1) ? $clog2(DIV_C) : 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_W'(DIV_C - 1)) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_a = tap_hit(32'(cnt_q), DIV_A);
  assign tick_b = tap_hit(32'(cnt_q), DIV_B);
  assign tick_c = tap_hit(32'(cnt_q), DIV_C);

  assert_tap_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_a |=> !tick_a);

  assert_tap_nest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_c |-> (tick_a && tick_b));

endmodule

// File: rtl/oe_pin_filter.sv
module oe_pin_filter #(
  parameter int SAMPLES     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_n,
  input  logic [1:0] mode,
  input  logic       restart,
  input  logic       tick_a,
  input  logic       tick_b,
  input  logic       tick_c,
  input  logic       clr,
  output logic       accept,
  output logic       flag
);
  import oe_pkg::*;

  localparam int RUN_W = $clog2(SAMPLES + 1);

  oe_mode_e               mode_e;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   s_now;
  logic                   prev_q;
  logic [RUN_W-1:0]       run_q;
  logic                   sel_tick;
  logic                   level_mode;
  logic                   accept_edge;
  logic                   accept_level;
  logic                   flag_q;

  assign mode_e = oe_mode_e'(mode);

  // Synchronizer, idle state high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
    end
  end
  assign s_now = sync_q[SYNC_STAGES-1];

  always_comb begin
    unique case (mode_e)
      MODE_TAP_A: sel_tick = tick_a;
      MODE_TAP_B: sel_tick = tick_b;
      MODE_TAP_C: sel_tick = tick_c;
      default:    sel_tick = 1'b0;
    endcase
  end
  assign level_mode = (mode_e != MODE_EDGE);

  // Edge history and low-run counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      run_q  <= '0;
    end else if (restart) begin
      prev_q <= 1'b0;
      run_q  <= '0;
    end else begin
      prev_q <= s_now;
      if (level_mode && sel_tick) begin
        if (s_now) begin
          run_q <= '0;
        end else if (run_q != RUN_W'(SAMPLES)) begin
          run_q <= run_q + 1'b1;
        end
      end
    end
  end

  assign accept_edge  = !level_mode && prev_q && !s_now;
  assign accept_level = level_mode && sel_tick && !s_now && (run_q == RUN_W'(SAMPLES - 1));
  assign accept       = !restart && (accept_edge || accept_level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= next_flag(flag_q, accept, clr);
    end
  end
  assign flag = flag_q;

  assert_edge_needs_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && accept) |-> (!s_now && $past(s_now)));

  assert_level_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (level_mode && accept) |-> sel_tick);

  assert_run_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_W'(SAMPLES));

  assert_accept_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> flag_q);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !accept) |=> !flag_q);

  assert_restart_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !accept);

endmodule

// File: rtl/oe_req_filter.sv
module oe_req_filter #(
  parameter int NUM_PINS    = 3,
  parameter int SAMPLES     = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_A       = 8,
  parameter int DIV_B       = 16,
  parameter int DIV_C       = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] oe_req_n,
  input  logic                bus_we,
  input  logic                bus_addr,
  input  logic [7:0]          bus_wdata,
  output logic [7:0]          bus_rdata,
  output logic [NUM_PINS-1:0] req_flags,
  output logic                req_any
);
  import oe_pkg::*;

  localparam logic [REG_W-1:0] MASK = field_mask(NUM_PINS);

  logic [REG_W-1:0]    mode_q;
  logic                wr_mode;
  logic                wr_clr;
  logic [NUM_PINS-1:0] restart;
  logic [NUM_PINS-1:0] clr;
  logic [NUM_PINS-1:0] accept;
  logic                tick_a;
  logic                tick_b;
  logic                tick_c;

  assign wr_mode = bus_we && !bus_addr;
  assign wr_clr  = bus_we && bus_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (wr_mode) begin
      mode_q <= bus_wdata & MASK;
    end
  end

  oe_prescaler #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) i_prescaler (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_a (tick_a),
    .tick_b (tick_b),
    .tick_c (tick_c)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign restart[g] = wr_mode &&
      (bus_wdata[FIELD_LSB + 2*g +: 2] != mode_q[FIELD_LSB + 2*g +: 2]);
    assign clr[g] = wr_clr && bus_wdata[g];

    oe_pin_filter #(.SAMPLES(SAMPLES), .SYNC_STAGES(SYNC_STAGES)) i_filter (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_n   (oe_req_n[g]),
      .mode    (mode_q[FIELD_LSB + 2*g +: 2]),
      .restart (restart[g]),
      .tick_a  (tick_a),
      .tick_b  (tick_b),
      .tick_c  (tick_c),
      .clr     (clr[g]),
      .accept  (accept[g]),
      .flag    (req_flags[g])
    );
  end

  assign req_any = |req_flags;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr) begin
      bus_rdata[NUM_PINS-1:0] = req_flags;
    end else begin
      bus_rdata = mode_q;
    end
  end

  assert_mode_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> (mode_q == ($past(bus_wdata) & MASK)));

  assert_any_rises_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|accept) |=> req_any);

endmodule

// File: tb/test_oe_req_filter.sv
`timescale 1ns/1ps
module test_oe_req_filter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] pin_n = 3'b111;
  logic       bus_we = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [2:0] req_flags;
  logic       req_any;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  oe_req_filter i_oe_req_filter (
    .clk       (clk),
    .rst_n     (rst_n),
    .oe_req_n  (pin_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .req_flags (req_flags),
    .req_any   (req_any)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic int div_of(input int code);
    return (code == 3) ? 128 : (4 << code);
  endfunction

  // rising edges until flag p is seen, or limit+1
  task automatic time_flag(input int p, input int limit, output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!req_flags[p] && n <= limit);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int n;
    int d;
    int first [3];

    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    chk(req_flags == 3'b000, "R1 flags", req_flags, 0);
    chk(req_any == 1'b0, "R1 req_any", req_any, 0);
    bus_rd(1'b0, rd);
    chk(rd == 8'h00, "R1 mode", rd, 0);

    // R2 field layout, low bits not stored
    bus_wr(1'b0, 8'hFF);
    bus_rd(1'b0, rd);
    chk(rd == 8'hFC, "R2 all ones", rd, 8'hFC);
    bus_wr(1'b0, 8'h9D);
    bus_rd(1'b0, rd);
    chk(rd == 8'h9C, "R2 pattern", rd, 8'h9C);
    bus_wr(1'b0, 8'h00);
    idle(4);

    // R3 edge timing on pin 0
    @(negedge clk) pin_n[0] = 1'b0;
    time_flag(0, 10, n);
    chk(n == 3, "R3 edge latency", n, 3);
    chk(req_flags == 3'b001, "R3 only pin0", req_flags, 1);
    chk(req_any == 1'b1, "R10 any set", req_any, 1);
    bus_rd(1'b1, rd);
    chk(rd == 8'h01, "R6 flag readback", rd, 1);
    pin_n[0] = 1'b1;
    idle(4);

    // R6 write 0 has no effect, write 1 clears
    bus_wr(1'b1, 8'h00);
    idle(1);
    chk(req_flags[0] == 1'b1, "R6 zero write", req_flags[0], 1);
    bus_wr(1'b1, 8'h01);
    chk(req_flags[0] == 1'b0, "R6 clear", req_flags[0], 0);
    chk(req_any == 1'b0, "R10 any clear", req_any, 0);

    // R7 clear on the acceptance edge
    pin_n[0] = 1'b0; idle(5); pin_n[0] = 1'b1; idle(4);
    chk(req_flags[0] == 1'b1, "R7 preset", req_flags[0], 1);
    @(negedge clk) pin_n[0] = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk) begin bus_we = 1'b1; bus_addr = 1'b1; bus_wdata = 8'h01; end
    @(posedge clk);
    @(negedge clk) bus_we = 1'b0;
    chk(req_flags[0] == 1'b1, "R7 accept wins", req_flags[0], 1);
    bus_wr(1'b1, 8'h01);
    chk(req_flags[0] == 1'b0, "R7 plain clear", req_flags[0], 0);
    pin_n[0] = 1'b1;
    idle(4);

    // R9 switch to edge mode while pin is low
    bus_wr(1'b0, 8'h04);
    idle(4);
    pin_n[0] = 1'b0;
    idle(20);
    bus_wr(1'b0, 8'h00);
    idle(20);
    chk(req_flags[0] == 1'b0, "R9 no false edge", req_flags[0], 0);
    pin_n[0] = 1'b1;
    idle(4);

    // R9 level count restarts at a rate change
    bus_wr(1'b0, 8'h04);
    bus_wr(1'b1, 8'h07);
    idle(4);
    pin_n[0] = 1'b0;
    idle(80);
    bus_wr(1'b0, 8'h08);
    time_flag(0, 400, n);
    chk(n >= 241 && n <= 256, "R9 restart window", n, 248);
    pin_n[0] = 1'b1;
    idle(4);

    // R4 R8 rates rotated over the three pins
    for (int rot = 0; rot < 3; rot++) begin
      logic [7:0] m;
      m = 8'h00;
      for (int p = 0; p < 3; p++) m[2 + 2*p +: 2] = 2'(((p + rot) % 3) + 1);
      pin_n = 3'b111;
      bus_wr(1'b0, m);
      idle(4);
      bus_wr(1'b1, 8'h07);
      chk(req_flags == 3'b000, "R8 cleared", req_flags, 0);
      @(negedge clk) pin_n = 3'b000;
      for (int p = 0; p < 3; p++) first[p] = -1;
      for (int c = 1; c <= 2100; c++) begin
        @(posedge clk);
        @(negedge clk);
        for (int p = 0; p < 3; p++)
          if (req_flags[p] && first[p] < 0) first[p] = c;
      end
      for (int p = 0; p < 3; p++) begin
        d = div_of(((p + rot) % 3) + 1);
        chk(first[p] >= 15*d + 3 && first[p] <= 16*d + 2, "R4 R8 level window",
            first[p], 16*d);
      end
    end

    // R11 pin held low after a clear does not re-trigger
    bus_wr(1'b1, 8'h07);
    idle(2200);
    chk(req_flags == 3'b000, "R11 no re-accept", req_flags, 0);
    pin_n = 3'b111;
    idle(4);

    // R5 short stretches at each rate
    for (int code = 1; code <= 3; code++) begin
      d = div_of(code);
      bus_wr(1'b0, 8'(code << 2));
      bus_wr(1'b1, 8'h07);
      idle(4);
      pin_n[0] = 1'b0; idle(15*d);
      pin_n[0] = 1'b1; idle(4*d);
      chk(req_flags[0] == 1'b0, "R5 15 samples", req_flags[0], 0);
      pin_n[0] = 1'b0; idle(15*d);
      pin_n[0] = 1'b1; idle(d);
      pin_n[0] = 1'b0; idle(15*d);
      pin_n[0] = 1'b1; idle(4*d);
      chk(req_flags[0] == 1'b0, "R5 split run", req_flags[0], 0);
      bus_wr(1'b0, 8'h00);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule